// File: doc/BRIEF.md
# GPIO Edge Interrupt Detector with Bank Aggregation

This block watches a vector of already-synchronized GPIO levels and records edges in a status register. Software chooses which pins react to rising edges and which react to falling edges. Each choice is held in a mask that is only ever changed through a pair of write strobes: one sets bits and one clears bits. A pin armed for both polarities reports any change of level. Detection looks only at the pin level, so a pin driven as an output can raise an event just as an input can.

The status bits are split into 16-pin groups, and each group drives its own level interrupt line. A small bank-enable word masks each line. This mask acts only on the line, so status capture goes on while the line is masked. Software acknowledges an event by writing ones to the status bits it has handled. All register decoding is done upstream: the block receives one write strobe per register, and every strobe shares a single data bus.

Top module: `gpio_edge_irq_agg`

## Requirements
- R1: After reset, the status word is zero, every bank line is low, and no pin is armed for either polarity. A pin toggle that follows reset, with no arming write, leaves the status word at zero.
- R2: Writing ones through the rising-set strobe arms those pins for rising edges. A 0→1 transition on an armed pin sets its status bit at the clock edge that first samples the high level.
- R3: Writing ones through the falling-set strobe arms those pins for falling edges. A 1→0 transition on an armed pin sets its status bit.
- R4: Writing ones through a clear strobe disarms those pins for that polarity. Writing all ones to both clear strobes disarms every pin. A transition on a disarmed pin sets no status bit.
- R5: When the set strobe and the clear strobe of one polarity both carry a 1 for a pin in the same cycle, that pin ends up armed.
- R6: A pin armed for both polarities sets its status bit on every change of level.
- R7: Status is write-one-to-clear. A 1 in the data clears that status bit, and a 0 in the data leaves that bit unchanged.
- R8: When an edge is detected in the same cycle as a clear of its status bit, the status bit stays set.
- R9: Status bits 15:0 drive bank line 0 and bits 31:16 drive bank line 1. A line is high while any bit of its half is set and its bank-enable bit is 1.
- R10: Bit b of the bank-enable word, written through its strobe from data bit b, gates bank line b. A 0 holds the line low but does not stop status capture.
- R11: An arming write takes effect from the next cycle. An edge sampled in the same cycle as the write is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | PIN_W | Synchronized pin levels |
| rise_set_we_i | input | 1 | Arm rising detection for pins whose data bit is 1 |
| rise_clr_we_i | input | 1 | Disarm rising detection for pins whose data bit is 1 |
| fall_set_we_i | input | 1 | Arm falling detection for pins whose data bit is 1 |
| fall_clr_we_i | input | 1 | Disarm falling detection for pins whose data bit is 1 |
| stat_clr_we_i | input | 1 | Clear the status bits whose data bit is 1 |
| bank_en_we_i | input | 1 | Load the bank-enable word from the low data bits |
| wdata_i | input | PIN_W | Write data shared by all strobes |
| status_o | output | PIN_W | Edge status readback |
| bank_irq_o | output | PIN_W/BANK_W | Per-bank level interrupt lines |

## Verification
The bench sweeps every pin through all four arming combinations and drives a rise and then a fall on each. This catches a design that swaps polarities, shifts a bit index, or decodes the mask onto the wrong pin. Directed cases cover the collisions: a set and a clear of the same arming bit in one cycle, where a design giving the clear priority loses the pin, and an edge arriving together with its own acknowledge, where a design giving the clear priority drops an event. Further cases cover an arming write in the same cycle as an edge, which a design that used the unregistered mask would capture, and a partial acknowledge, which a design clearing whole words would get wrong. The bank checks cover two faults: a line that swaps halves, and a mask that also blocks capture, so that the event would be missing from status once the line is unmasked.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned DEF_PIN_W  = 32;
  localparam int unsigned DEF_BANK_W = 16;

  function automatic int unsigned bank_cnt(int unsigned pins, int unsigned per_bank);
    return (pins + per_bank - 1) / per_bank;
  endfunction
endpackage

// File: rtl/gpio_edge_en_pair.sv
module gpio_edge_en_pair #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] set_m, clr_m;

  assign set_m = set_we_i ? wdata_i : '0;
  assign clr_m = clr_we_i ? wdata_i : '0;

  // set applied after clear: set wins on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q & ~clr_m) | set_m;
  end

  assign en_o = en_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic up, dn;
    assign up        =  pin_i[i] & ~prev_q[i];
    assign dn        = ~pin_i[i] &  prev_q[i];
    assign edge_o[i] = (up & rise_en_i[i]) | (dn & fall_en_i[i]);
  end
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] edge_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] clr_m;

  assign clr_m = clr_we_i ? wdata_i : '0;

  // new edge dominates a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_m) | edge_i;
  end

  assign status_o = stat_q;
endmodule

// File: rtl/gpio_edge_bank_gate.sv
module gpio_edge_bank_gate #(
  parameter int unsigned W      = 32,
  parameter int unsigned BANK_W = 16,
  localparam int unsigned NB    = gpio_edge_pkg::bank_cnt(W, BANK_W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  status_i,
  input  logic          en_we_i,
  input  logic [NB-1:0] en_wdata_i,
  output logic [NB-1:0] en_o,
  output logic [NB-1:0] irq_o
);
  logic [NB-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int unsigned LO = b * BANK_W;
    localparam int unsigned HI = ((LO + BANK_W) > W) ? W - 1 : LO + BANK_W - 1;
    logic any;
    assign any      = |status_i[HI:LO];
    assign irq_o[b] = any & en_q[b];
  end

  assign en_o = en_q;
endmodule

// File: rtl/gpio_edge_irq_agg.sv
module gpio_edge_irq_agg #(
  parameter int unsigned PIN_W  = gpio_edge_pkg::DEF_PIN_W,
  parameter int unsigned BANK_W = gpio_edge_pkg::DEF_BANK_W,
  localparam int unsigned NB    = gpio_edge_pkg::bank_cnt(PIN_W, BANK_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIN_W-1:0] pin_i,
  input  logic             rise_set_we_i,
  input  logic             rise_clr_we_i,
  input  logic             fall_set_we_i,
  input  logic             fall_clr_we_i,
  input  logic             stat_clr_we_i,
  input  logic             bank_en_we_i,
  input  logic [PIN_W-1:0] wdata_i,
  output logic [PIN_W-1:0] status_o,
  output logic [NB-1:0]    bank_irq_o
);
  logic [PIN_W-1:0] rise_en_q, fall_en_q, edges;
  logic [NB-1:0]    bank_en_q;

  gpio_edge_en_pair #(.W(PIN_W)) u_rise_en (
    .clk_i, .rst_ni,
    .set_we_i(rise_set_we_i), .clr_we_i(rise_clr_we_i),
    .wdata_i, .en_o(rise_en_q)
  );

  gpio_edge_en_pair #(.W(PIN_W)) u_fall_en (
    .clk_i, .rst_ni,
    .set_we_i(fall_set_we_i), .clr_we_i(fall_clr_we_i),
    .wdata_i, .en_o(fall_en_q)
  );

  gpio_edge_detect #(.W(PIN_W)) u_detect (
    .clk_i, .rst_ni, .pin_i,
    .rise_en_i(rise_en_q), .fall_en_i(fall_en_q),
    .edge_o(edges)
  );

  gpio_edge_status #(.W(PIN_W)) u_status (
    .clk_i, .rst_ni,
    .edge_i(edges), .clr_we_i(stat_clr_we_i), .wdata_i,
    .status_o
  );

  gpio_edge_bank_gate #(.W(PIN_W), .BANK_W(BANK_W)) u_bank (
    .clk_i, .rst_ni,
    .status_i(status_o), .en_we_i(bank_en_we_i),
    .en_wdata_i(wdata_i[NB-1:0]),
    .en_o(bank_en_q), .irq_o(bank_irq_o)
  );
endmodule

// File: rtl/gpio_edge_irq_agg_chk.sv
module gpio_edge_irq_agg_chk #(
  parameter int unsigned PIN_W  = 32,
  parameter int unsigned BANK_W = 16,
  localparam int unsigned NB    = gpio_edge_pkg::bank_cnt(PIN_W, BANK_W)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PIN_W-1:0] pin_i,
  input logic             stat_clr_we_i,
  input logic [PIN_W-1:0] wdata_i,
  input logic [PIN_W-1:0] status_o,
  input logic [NB-1:0]    bank_irq_o,
  input logic [PIN_W-1:0] rise_en_q,
  input logic [PIN_W-1:0] fall_en_q
);
  logic [PIN_W-1:0] clr_mask;
  assign clr_mask = stat_clr_we_i ? wdata_i : '0;

  assert_w1c_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & $past(status_o & ~clr_mask)) == $past(status_o & ~clr_mask)));

  assert_w1c_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & $past(clr_mask) & ~($past(pin_i) ^ $past(pin_i, 2))) == '0));

  assert_set_needs_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & ~($past(pin_i) ^ $past(pin_i, 2))) == '0));

  assert_set_needs_arm_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(rise_en_q | fall_en_q)) == '0));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int unsigned LO = b * BANK_W;
    localparam int unsigned HI = ((LO + BANK_W) > PIN_W) ? PIN_W - 1 : LO + BANK_W - 1;
    assert_line_has_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_irq_o[b] |-> (|status_o[HI:LO]));
  end
endmodule

bind gpio_edge_irq_agg gpio_edge_irq_agg_chk #(.PIN_W(PIN_W), .BANK_W(BANK_W)) u_chk (
  .clk_i, .rst_ni, .pin_i, .stat_clr_we_i, .wdata_i,
  .status_o, .bank_irq_o, .rise_en_q, .fall_en_q
);

// File: tb/gpio_edge_irq_agg_tb_top.sv
module gpio_edge_irq_agg_tb_top;
  localparam int unsigned PW = 32;
  localparam int unsigned BW = 16;
  localparam int unsigned NB = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [PW-1:0] pin_i = '0, wdata_i = '0;
  logic rise_set_we_i = 0, rise_clr_we_i = 0, fall_set_we_i = 0, fall_clr_we_i = 0;
  logic stat_clr_we_i = 0, bank_en_we_i = 0;
  logic [PW-1:0] status_o;
  logic [NB-1:0] bank_irq_o;

  int n_run = 0, n_fail = 0;
  logic [PW-1:0] m_ren = '0, m_fen = '0, m_stat = '0, m_prev = '0;
  logic [NB-1:0] m_ben = '0;

  always #2.5 clk_i = ~clk_i;

  gpio_edge_irq_agg #(.PIN_W(PW), .BANK_W(BW)) dut_i (.*);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] exp_irq();
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = (|m_stat[b*BW +: BW]) & m_ben[b];
    return r;
  endfunction

  // one clock: reference update at the edge, compare at the following negedge
  task automatic tick(string req);
    logic [PW-1:0] up, dn, cm, nr, nf;
    @(posedge clk_i);
    up = pin_i & ~m_prev;
    dn = ~pin_i & m_prev;
    cm = stat_clr_we_i ? wdata_i : '0;
    m_stat = (m_stat & ~cm) | (up & m_ren) | (dn & m_fen);
    nr = m_ren; nf = m_fen;
    if (rise_clr_we_i) nr = nr & ~wdata_i;
    if (rise_set_we_i) nr = nr | wdata_i;
    if (fall_clr_we_i) nf = nf & ~wdata_i;
    if (fall_set_we_i) nf = nf | wdata_i;
    m_ren = nr; m_fen = nf;
    if (bank_en_we_i) m_ben = wdata_i[NB-1:0];
    m_prev = pin_i;
    @(negedge clk_i);
    chk(req, "status", 64'(status_o), 64'(m_stat));
    chk(req, "bank_irq", 64'(bank_irq_o), 64'(exp_irq()));
    {rise_set_we_i, rise_clr_we_i, fall_set_we_i, fall_clr_we_i, stat_clr_we_i, bank_en_we_i} = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "status", 64'(status_o), 64'h0);
    chk("R1", "bank_irq", 64'(bank_irq_o), 64'h0);
    pin_i = '1; tick("R1");
    pin_i = '0; tick("R1");

    wdata_i = '1; bank_en_we_i = 1; tick("R10");

    // sweep: every pin, every arming combination, rise then fall
    for (int i = 0; i < PW; i++) begin
      for (int mode = 0; mode < 4; mode++) begin
        string tag;
        case (mode)
          0: tag = "R4";
          1: tag = "R2";
          2: tag = "R3";
          default: tag = "R6";
        endcase
        wdata_i = '1; rise_clr_we_i = 1; fall_clr_we_i = 1; tick("R4");
        wdata_i = PW'(1) << i; rise_set_we_i = mode[0]; fall_set_we_i = mode[1]; tick(tag);
        pin_i[i] = 1'b1; tick(tag);
        pin_i[i] = 1'b0; tick(tag);
        wdata_i = '1; stat_clr_we_i = 1; tick("R7");
      end
    end

    // R5: set and clear of same bit in one cycle
    wdata_i = '1; rise_clr_we_i = 1; fall_clr_we_i = 1; tick("R4");
    wdata_i = 32'h8; rise_set_we_i = 1; rise_clr_we_i = 1; tick("R5");
    pin_i[3] = 1; tick("R5");
    chk("R5", "bit3", 64'(status_o[3]), 64'h1);
    pin_i[3] = 0; tick("R5");

    // R11: arm in same cycle as edge -> missed
    wdata_i = '1; stat_clr_we_i = 1; tick("R7");
    wdata_i = 32'h0000_0100; rise_set_we_i = 1; pin_i[8] = 1; tick("R11");
    chk("R11", "bit8", 64'(status_o[8]), 64'h0);
    pin_i[8] = 0; tick("R11");
    pin_i[8] = 1; tick("R11");
    chk("R11", "bit8 later", 64'(status_o[8]), 64'h1);

    // R7: partial acknowledge
    wdata_i = '1; rise_set_we_i = 1; tick("R2");
    pin_i = '1; tick("R2");
    wdata_i = 32'hA5A5_0F0F; stat_clr_we_i = 1; tick("R7");
    chk("R7", "partial", 64'(status_o), 64'h5A5A_F0F0);
    pin_i = '0; tick("R7");

    // R8: edge together with its own clear
    wdata_i = '1; stat_clr_we_i = 1; tick("R7");
    pin_i[5] = 1; wdata_i = 32'h20; stat_clr_we_i = 1; tick("R8");
    chk("R8", "bit5", 64'(status_o[5]), 64'h1);
    pin_i[5] = 0; wdata_i = '1; stat_clr_we_i = 1; tick("R7");

    // R9/R10: bank mapping and gating
    wdata_i = 32'h1; bank_en_we_i = 1; tick("R10");
    pin_i[20] = 1; tick("R10");
    chk("R10", "captured while masked", 64'(status_o[20]), 64'h1);
    chk("R10", "line1 masked", 64'(bank_irq_o), 64'h0);
    wdata_i = 32'h3; bank_en_we_i = 1; tick("R9");
    chk("R9", "line1 up", 64'(bank_irq_o), 64'h2);
    pin_i[2] = 1; tick("R9");
    chk("R9", "both lines", 64'(bank_irq_o), 64'h3);
    wdata_i = 32'h0010_0000; stat_clr_we_i = 1; tick("R9");
    chk("R9", "line0 only", 64'(bank_irq_o), 64'h1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule